// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

The block decides whether an outgoing transaction layer packet may be sent, based on the flow-control credit the link partner has advertised. Credit is kept for three traffic classes: posted, non-posted and completion. Each class has two pools. The header pool counts header credits, each worth 20 bytes of header. The data pool counts data credits, each worth 16 bytes of payload. The surrounding logic supplies a credit limit for every pool and a per-pool flag that marks the pool as unlimited.

A request carries a traffic class and a payload length in bytes, and is presented on a valid/ready port. `req_ready` is a combinational answer: it is high when every pool the packet draws from has enough credit. When valid and ready are both high, the packet is admitted. The consumed counters then advance at that clock edge, and a six-bit `consumed` vector pulses one bit per credit type used. When credit is short, the request waits with ready low until a limit update frees enough room.

The consumed counters are modular. Room left in a pool is taken as (limit − consumed) modulo 2^width. Advertised limits may therefore wrap freely, as they do on a long-running link.

Top module: `txfc_credit_tracker`

## Requirements
- R1: The `consumed` and `inf_mask` vectors share one bit order: bit 5 posted header, bit 4 posted data, bit 3 non-posted header, bit 2 non-posted data, bit 1 completion header, bit 0 completion data. `req_class` encodes 0 as posted, 1 as non-posted and 2 as completion.
- R2: For each admitted request, the `consumed` bits of that request's types are high for exactly one clock cycle. That cycle is the one that follows the edge at which valid and ready were both high.
- R3: An admission with payload length 0 uses only one header credit of its class. A non-zero length uses one header credit plus data credit of the same class. No other class's bits or counters change.
- R4: The data credits needed equal ceil(length/16). On admission, the class's header counter adds 1 and its data counter adds that amount, both modulo 2^width (8 bits for header, 12 bits for data).
- R5: Ready is high only if (limit − consumed) mod 2^width is at least 1 for the class's header pool. For a non-zero length, it must also be at least ceil(length/16) for the class's data pool. The check is exact at the boundary and works across counter wraparound.
- R6: A pool whose `inf_mask` bit is set never holds back a request, whatever its limit. Its counter still advances on admission.
- R7: While a request is refused, no counter moves and `consumed` stays zero.
- R8: Reset clears all six consumed counters and the `consumed` vector to zero.
- R9: A `req_class` of 3 is reserved and never sees ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Enough credit for the presented request |
| req_class | input | 2 | Traffic class (0 posted, 1 non-posted, 2 completion) |
| req_len | input | LEN_W | Payload length in bytes |
| lim_hdr_posted | input | HDR_W | Posted header credit limit |
| lim_dat_posted | input | DAT_W | Posted data credit limit |
| lim_hdr_nonposted | input | HDR_W | Non-posted header credit limit |
| lim_dat_nonposted | input | DAT_W | Non-posted data credit limit |
| lim_hdr_compl | input | HDR_W | Completion header credit limit |
| lim_dat_compl | input | DAT_W | Completion data credit limit |
| inf_mask | input | 6 | Per-pool unlimited flags |
| consumed | output | 6 | One-cycle per-type consumption pulses |
| used_hdr_posted | output | HDR_W | Posted header consumed counter |
| used_dat_posted | output | DAT_W | Posted data consumed counter |
| used_hdr_nonposted | output | HDR_W | Non-posted header consumed counter |
| used_dat_nonposted | output | DAT_W | Non-posted data consumed counter |
| used_hdr_compl | output | HDR_W | Completion header consumed counter |
| used_dat_compl | output | DAT_W | Completion data consumed counter |

## Verification
The bench targets the rounding edges of the length conversion, at 0, 1, 15, 16, 17 and 4096 bytes. A wrong divide there over- or under-charges the data counter by one credit. It sets each limit to exactly the needed amount and to one less. An off-by-one comparison would admit a packet the partner cannot take, or stall forever on one it can. It drives header and data counters through their modular wrap. A non-modular room computation would then refuse packets or let them through at random. It also checks three more cases: that an unlimited flag admits a request against a zero-room limit, that a reserved class never gets ready, and that a refused request leaves counters and pulses untouched.

// File: rtl/txfc_pkg.sv
`timescale 1ns/1ps
package txfc_pkg;

  localparam int NUM_CLASS = 3;
  localparam int NUM_TYPES = 2 * NUM_CLASS;

  typedef enum logic [1:0] {
    TC_POSTED    = 2'd0,
    TC_NONPOSTED = 2'd1,
    TC_COMPL     = 2'd2,
    TC_RSVD      = 2'd3
  } tclass_e;

  // Bit position of a class's header and data type in the six-bit vectors.
  function automatic int hdr_bit(input int cls);
    return NUM_TYPES - 1 - 2 * cls;
  endfunction

  function automatic int dat_bit(input int cls);
    return NUM_TYPES - 2 - 2 * cls;
  endfunction

endpackage

// File: rtl/txfc_demand.sv
`timescale 1ns/1ps
// Turns a request (class, byte length) into per-pool credit demand.
module txfc_demand
  import txfc_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int DAT_W = 12
) (
  input  logic [1:0]       cls,
  input  logic [LEN_W-1:0] len,
  output logic             cls_valid,
  output logic [NUM_CLASS-1:0] hdr_need,
  output logic [DAT_W-1:0] dat_need [NUM_CLASS]
);

  localparam int CRED_W = LEN_W - 3;

  logic [LEN_W:0]    rounded;
  logic [CRED_W-1:0] credits;

  always_comb begin
    rounded = {1'b0, len} + (LEN_W+1)'(15);
    credits = rounded[LEN_W:4];
  end

  assign cls_valid = (tclass_e'(cls) != TC_RSVD);

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    logic sel;
    assign sel         = (cls == 2'(c));
    assign hdr_need[c] = sel;
    assign dat_need[c] = sel ? DAT_W'(credits) : '0;
  end

endmodule

// File: rtl/txfc_pool.sv
`timescale 1ns/1ps
// One credit pool: modular consumed counter, room check and consumption pulse.
module txfc_pool #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] limit,
  input  logic         unlimited,
  input  logic [W-1:0] need,
  input  logic         take,
  output logic         ok,
  output logic [W-1:0] count,
  output logic         pulse
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;
  logic [W-1:0] room;
  logic         en;

  assign room = limit - cnt_q;
  assign ok   = unlimited | (room >= need);
  assign en   = take & (|need);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (en) begin
      cnt_d   = cnt_q + need;
      pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign count = cnt_q;
  assign pulse = pulse_q;

  // Admission from the top must never overdraw a bounded pool.
  p_no_overdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !unlimited) |-> ((limit - cnt_q) >= need));

  // A use shows up as a one-cycle pulse and the exact counter step.
  p_pulse_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (pulse && (count == $past(cnt_q + need))));

  // Without a use, the counter holds.
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

endmodule

// File: rtl/txfc_credit_tracker.sv
`timescale 1ns/1ps
module txfc_credit_tracker
  import txfc_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_class,
  input  logic [LEN_W-1:0] req_len,
  input  logic [HDR_W-1:0] lim_hdr_posted,
  input  logic [DAT_W-1:0] lim_dat_posted,
  input  logic [HDR_W-1:0] lim_hdr_nonposted,
  input  logic [DAT_W-1:0] lim_dat_nonposted,
  input  logic [HDR_W-1:0] lim_hdr_compl,
  input  logic [DAT_W-1:0] lim_dat_compl,
  input  logic [5:0]       inf_mask,
  output logic [5:0]       consumed,
  output logic [HDR_W-1:0] used_hdr_posted,
  output logic [DAT_W-1:0] used_dat_posted,
  output logic [HDR_W-1:0] used_hdr_nonposted,
  output logic [DAT_W-1:0] used_dat_nonposted,
  output logic [HDR_W-1:0] used_hdr_compl,
  output logic [DAT_W-1:0] used_dat_compl
);

  logic                 cls_valid;
  logic [NUM_CLASS-1:0] hdr_need;
  logic [DAT_W-1:0]     dat_need [NUM_CLASS];
  logic [HDR_W-1:0]     lim_h    [NUM_CLASS];
  logic [DAT_W-1:0]     lim_d    [NUM_CLASS];
  logic [HDR_W-1:0]     cnt_h    [NUM_CLASS];
  logic [DAT_W-1:0]     cnt_d    [NUM_CLASS];
  logic [NUM_CLASS-1:0] ok_h, ok_d, pls_h, pls_d;
  logic                 accept;

  assign lim_h[0] = lim_hdr_posted;
  assign lim_h[1] = lim_hdr_nonposted;
  assign lim_h[2] = lim_hdr_compl;
  assign lim_d[0] = lim_dat_posted;
  assign lim_d[1] = lim_dat_nonposted;
  assign lim_d[2] = lim_dat_compl;

  txfc_demand #(.LEN_W(LEN_W), .DAT_W(DAT_W)) u_demand (
    .cls       (req_class),
    .len       (req_len),
    .cls_valid (cls_valid),
    .hdr_need  (hdr_need),
    .dat_need  (dat_need)
  );

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_pool
    txfc_pool #(.W(HDR_W)) u_hdr (
      .clk       (clk),
      .rst_n     (rst_n),
      .limit     (lim_h[c]),
      .unlimited (inf_mask[hdr_bit(c)]),
      .need      ({{(HDR_W-1){1'b0}}, hdr_need[c]}),
      .take      (accept),
      .ok        (ok_h[c]),
      .count     (cnt_h[c]),
      .pulse     (pls_h[c])
    );
    txfc_pool #(.W(DAT_W)) u_dat (
      .clk       (clk),
      .rst_n     (rst_n),
      .limit     (lim_d[c]),
      .unlimited (inf_mask[dat_bit(c)]),
      .need      (dat_need[c]),
      .take      (accept),
      .ok        (ok_d[c]),
      .count     (cnt_d[c]),
      .pulse     (pls_d[c])
    );
  end

  // Pools of unselected classes see zero demand, so they always report ok.
  assign req_ready = cls_valid & (&ok_h) & (&ok_d);
  assign accept    = req_valid & req_ready;

  always_comb begin
    consumed = '0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      consumed[hdr_bit(c)] = pls_h[c];
      consumed[dat_bit(c)] = pls_d[c];
    end
  end

  assign used_hdr_posted    = cnt_h[0];
  assign used_hdr_nonposted = cnt_h[1];
  assign used_hdr_compl     = cnt_h[2];
  assign used_dat_posted    = cnt_d[0];
  assign used_dat_nonposted = cnt_d[1];
  assign used_dat_compl     = cnt_d[2];

  // Data credit never goes out without a header of the same class; at most one class per cycle.
  p_class_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((consumed[4] & !consumed[5]) | (consumed[2] & !consumed[3]) |
      (consumed[0] & !consumed[1])) == 1'b0) && ($countones(consumed) <= 2));

  p_rsvd_never_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_class == 2'd3) |-> !req_ready);

  p_refused_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (consumed == 6'd0));

endmodule

// File: tb/sim_txfc_credit_tracker.sv
`timescale 1ns/1ps
module sim_txfc_credit_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_class = 2'd0;
  logic [12:0] req_len = '0;
  logic [5:0]  inf_mask = '0;
  logic [5:0]  consumed;
  logic [7:0]  lh [3];
  logic [11:0] ld [3];
  logic [7:0]  uh [3];
  logic [11:0] ud [3];
  logic [7:0]  mh [3];
  logic [11:0] md [3];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  txfc_credit_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_len(req_len),
    .lim_hdr_posted(lh[0]), .lim_dat_posted(ld[0]),
    .lim_hdr_nonposted(lh[1]), .lim_dat_nonposted(ld[1]),
    .lim_hdr_compl(lh[2]), .lim_dat_compl(ld[2]),
    .inf_mask(inf_mask), .consumed(consumed),
    .used_hdr_posted(uh[0]), .used_dat_posted(ud[0]),
    .used_hdr_nonposted(uh[1]), .used_dat_nonposted(ud[1]),
    .used_hdr_compl(uh[2]), .used_dat_compl(ud[2])
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    for (int c = 0; c < 3; c++) begin
      chk(uh[c] == mh[c], req, int'(uh[c]), int'(mh[c]));
      chk(ud[c] == md[c], req, int'(ud[c]), int'(md[c]));
    end
  endtask

  // One request: check ready, the pulse cycle, the following quiet cycle and counters.
  task automatic step(input int cls, input int len, input string req);
    bit exp_rdy;
    int need;
    logic [5:0] exp_cons;
    @(negedge clk);
    req_class = 2'(cls);
    req_len   = 13'(len);
    req_valid = 1'b1;
    need = (len + 15) / 16;
    exp_cons = '0;
    if (cls == 3) exp_rdy = 1'b0;
    else begin
      exp_rdy = (inf_mask[5-2*cls] || (8'(lh[cls] - mh[cls]) >= 8'd1)) &&
                (len == 0 || inf_mask[4-2*cls] || (12'(ld[cls] - md[cls]) >= 12'(need)));
    end
    #1;
    chk(req_ready == exp_rdy, req, int'(req_ready), int'(exp_rdy));
    @(posedge clk);
    #1;
    if (exp_rdy) begin
      mh[cls] = mh[cls] + 8'd1;
      md[cls] = md[cls] + 12'(need);
      exp_cons[5-2*cls] = 1'b1;
      if (len != 0) exp_cons[4-2*cls] = 1'b1;
    end
    chk(consumed == exp_cons, req, int'(consumed), int'(exp_cons));
    chk_counts(req);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(consumed == 6'd0, "R2 single-cycle pulse", int'(consumed), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      lh[c] = '0; ld[c] = '0; mh[c] = '0; md[c] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(consumed == 6'd0, "R8 reset pulses", int'(consumed), 0);
    chk_counts("R8 reset counters");
    @(negedge clk);
    rst_n = 1'b1;
    chk_counts("R8 counters after release");

    // R4 R1 R3: sweep every length for every class with all pools unlimited.
    inf_mask = 6'h3F;
    for (int c = 0; c < 3; c++)
      for (int len = 0; len <= 4096; len++)
        step(c, len, "R4 R1 R3 length sweep");

    // R5: boundary limits, exact and one short, for rounding-edge lengths.
    inf_mask = 6'h00;
    for (int c = 0; c < 3; c++) begin
      int lens [7] = '{0, 1, 15, 16, 17, 100, 4096};
      foreach (lens[i]) begin
        int need = (lens[i] + 15) / 16;
        lh[c] = mh[c] + 8'd1;
        if (need > 0) begin
          ld[c] = md[c] + 12'(need) - 12'd1;
          step(c, lens[i], "R5 R7 one data credit short");
        end
        ld[c] = md[c] + 12'(need);
        step(c, lens[i], "R5 exact data room");
        lh[c] = mh[c];
        ld[c] = md[c] + 12'd300;
        step(c, lens[i], "R5 R7 header exhausted");
      end
    end

    // R5: header counter wrap with exactly one credit of room each time.
    for (int i = 0; i < 300; i++) begin
      lh[0] = mh[0] + 8'd1;
      step(0, 0, "R5 header wrap");
    end
    // R5: data counter wrap with exact room for full-size payloads.
    for (int i = 0; i < 20; i++) begin
      lh[1] = mh[1] + 8'd1;
      ld[1] = md[1] + 12'd256;
      step(1, 4096, "R5 data wrap");
    end

    // R6: unlimited flags bypass zero-room limits, counters still advance.
    for (int c = 0; c < 3; c++) begin
      lh[c] = mh[c]; ld[c] = md[c];
      inf_mask = 6'h00;
      step(c, 64, "R6 R7 no room refused");
      inf_mask = 6'(1 << (5-2*c));
      step(c, 0, "R6 header unlimited");
      lh[c] = mh[c];
      inf_mask = 6'(3 << (4-2*c));
      step(c, 64, "R6 both unlimited");
      inf_mask = 6'(1 << (4-2*c));
      lh[c] = mh[c] + 8'd1;
      step(c, 33, "R6 data unlimited");
    end

    // R9: reserved class never ready, even with everything unlimited.
    inf_mask = 6'h3F;
    step(3, 0, "R9 reserved class");
    step(3, 200, "R9 reserved class");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule